// File: doc/BRIEF.md
# GPIO Controller with Per-Line Interrupt Outputs

This block is a general-purpose I/O peripheral with 32 lines behind a single-port, word-wide memory-mapped register interface. Software chooses each line's direction and output level, reads the synchronised pad values, and can raise or drop individual output bits atomically by writing a mask to a dedicated address. Output-enabled lines drive their pads from the output level register. Input pads pass through a two-flop synchroniser before anything else uses them.

The lower sixteen lines each have their own interrupt wire to an external interrupt controller. The output level bit of each such line also selects the interrupt polarity. A per-line edge-mode bit changes the line into a pulse source that fires on either pin transition. Reads are combinational from the current address. Writes take effect on the clock edge that samples the write enable.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: While reset is asserted, and directly after it, every register reads 0. pad_oe and pad_out are all 0. With all pads low, irq_out is all 0.
- R2: The drive-enable register at byte offset 0x00 is read/write. Bit i = 1 asserts pad_oe[i], and bit i = 0 makes line i an input.
- R3: The output level register at offset 0x10 is read/write, and pad_out[i] always equals its bit i.
- R4: A write to offset 0x18 sets every output level bit whose write-data bit is 1 and leaves the other bits unchanged. Reads of 0x18 return 0.
- R5: A write to offset 0x20 clears every output level bit whose write-data bit is 1 and leaves the other bits unchanged. Reads of 0x20 return 0.
- R6: Offset 0x08 returns the pad inputs of all lines two clock edges after they are sampled, whatever the direction. Writes to 0x08 have no effect.
- R7: The edge-mode register at offset 0x30 is read/write.
- R8: For lines 0 to 15 with edge-mode 0, irq_out[i] equals the synchronised pin XOR output level bit i. This holds in the same cycle, with no extra register.
- R9: For lines 0 to 15 with edge-mode 1, irq_out[i] is high for exactly the cycle in which the synchronised pin differs from its value one cycle earlier.
- R10: Reads of any other offset return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Byte address of the register accessed |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pad_in | input | 32 | Raw pad input values, asynchronous |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables |
| irq_out | output | 16 | One interrupt wire per line 0 to 15 |

## Verification
The bench targets overlap between the atomic set and clear masks and the current level. A design that ORs or ANDs the wrong operand would disturb bits that were written as 0. It also checks that writes to the input and undefined offsets are dropped, since a loose address decode would silently corrupt the drive-enable or level registers. Pins are toggled on every cycle while the edge-mode and level bits change underneath them. An edge detector with a stale previous sample would emit a pulse on a mode switch or miss back-to-back transitions. A missing synchroniser stage would show up as pin data and interrupts one cycle early.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

   localparam int unsigned WORD_W = 32;

   // byte offsets; software depends on these
   localparam int unsigned OFS_DRIVE = 'h00;
   localparam int unsigned OFS_PIN   = 'h08;
   localparam int unsigned OFS_LEVEL = 'h10;
   localparam int unsigned OFS_RAISE = 'h18;
   localparam int unsigned OFS_DROP  = 'h20;
   localparam int unsigned OFS_EDGE  = 'h30;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_DRIVE,
      SEL_PIN,
      SEL_LEVEL,
      SEL_RAISE,
      SEL_DROP,
      SEL_EDGE
   } reg_sel_e;

   function automatic reg_sel_e decode_ofs(input logic [31:0] ofs);
      reg_sel_e sel;
      case (ofs)
         OFS_DRIVE: sel = SEL_DRIVE;
         OFS_PIN:   sel = SEL_PIN;
         OFS_LEVEL: sel = SEL_LEVEL;
         OFS_RAISE: sel = SEL_RAISE;
         OFS_DROP:  sel = SEL_DROP;
         OFS_EDGE:  sel = SEL_EDGE;
         default:   sel = SEL_NONE;
      endcase
      return sel;
   endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int unsigned WIDTH  = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);

   localparam int unsigned LAST = STAGES - 1;

   initial begin
      if (STAGES < 2) $fatal(1, "gpio_sync: STAGES must be at least 2");
      if (WIDTH < 1)  $fatal(1, "gpio_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
      end else begin
         stage_q[0] <= async_in;
         for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      end
   end

   assign sync_out = stage_q[LAST];

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
   import gpio_irq_pkg::*;
#(
   parameter int unsigned LINES  = 32,
   parameter int unsigned ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   input  logic [WORD_W-1:0] wdata,
   input  logic [LINES-1:0]  pin_sync,
   output logic [LINES-1:0]  drive_q,
   output logic [LINES-1:0]  level_q,
   output logic [LINES-1:0]  edge_q,
   output logic [WORD_W-1:0] rdata
);

   initial begin
      if (LINES > WORD_W) $fatal(1, "gpio_regs: LINES exceeds word width");
      if (ADDR_W < 6)     $fatal(1, "gpio_regs: ADDR_W too narrow for map");
      if (ADDR_W > 32)    $fatal(1, "gpio_regs: ADDR_W wider than 32");
   end

   reg_sel_e         sel;
   logic [LINES-1:0] wmask;
   logic [LINES-1:0] drive_d, level_d, edge_d;

   assign sel   = decode_ofs(32'(addr));
   assign wmask = wdata[LINES-1:0];

   always_comb begin
      drive_d = drive_q;
      level_d = level_q;
      edge_d  = edge_q;
      if (we) begin
         case (sel)
            SEL_DRIVE: drive_d = wmask;
            SEL_LEVEL: level_d = wmask;
            SEL_RAISE: level_d = level_q | wmask;
            SEL_DROP:  level_d = level_q & ~wmask;
            SEL_EDGE:  edge_d  = wmask;
            default:   ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drive_q <= '0;
         level_q <= '0;
         edge_q  <= '0;
      end else begin
         drive_q <= drive_d;
         level_q <= level_d;
         edge_q  <= edge_d;
      end
   end

   always_comb begin
      rdata = '0;
      case (sel)
         SEL_DRIVE: rdata[LINES-1:0] = drive_q;
         SEL_PIN:   rdata[LINES-1:0] = pin_sync;
         SEL_LEVEL: rdata[LINES-1:0] = level_q;
         SEL_EDGE:  rdata[LINES-1:0] = edge_q;
         default:   rdata = '0;
      endcase
   end

endmodule

// File: rtl/gpio_irq_gen.sv
module gpio_irq_gen #(
   parameter int unsigned IRQ_LINES    = 16,
   parameter bit          EDGE_SUPPORT = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [IRQ_LINES-1:0] pin_sync,
   input  logic [IRQ_LINES-1:0] level,
   input  logic [IRQ_LINES-1:0] edge_any,
   output logic [IRQ_LINES-1:0] irq
);

   initial begin
      if (IRQ_LINES < 1) $fatal(1, "gpio_irq_gen: IRQ_LINES must be at least 1");
   end

   for (genvar i = 0; i < IRQ_LINES; i++) begin : g_line
      logic polar;
      assign polar = pin_sync[i] ^ level[i];

      if (EDGE_SUPPORT) begin : g_edge
         logic prev_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= pin_sync[i];
         end
         assign irq[i] = edge_any[i] ? (pin_sync[i] ^ prev_q) : polar;
      end else begin : g_level_only
         logic unused_mode;
         assign unused_mode = edge_any[i];
         assign irq[i] = polar;
      end
   end

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
   import gpio_irq_pkg::*;
#(
   parameter int unsigned LINES       = 32,
   parameter int unsigned IRQ_LINES   = 16,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic                 bus_we,
   input  logic [31:0]          bus_wdata,
   output logic [31:0]          bus_rdata,
   input  logic [LINES-1:0]     pad_in,
   output logic [LINES-1:0]     pad_out,
   output logic [LINES-1:0]     pad_oe,
   output logic [IRQ_LINES-1:0] irq_out
);

   initial begin
      if (IRQ_LINES > LINES) $fatal(1, "gpio_irq_ctrl: IRQ_LINES exceeds LINES");
      if (LINES > WORD_W)    $fatal(1, "gpio_irq_ctrl: LINES exceeds word width");
   end

   logic [LINES-1:0] pin_sync;
   logic [LINES-1:0] drive_q, level_q, edge_q;

   gpio_sync #(
      .WIDTH  (LINES),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (pad_in),
      .sync_out (pin_sync)
   );

   gpio_regs #(
      .LINES  (LINES),
      .ADDR_W (ADDR_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr     (bus_addr),
      .we       (bus_we),
      .wdata    (bus_wdata),
      .pin_sync (pin_sync),
      .drive_q  (drive_q),
      .level_q  (level_q),
      .edge_q   (edge_q),
      .rdata    (bus_rdata)
   );

   gpio_irq_gen #(
      .IRQ_LINES    (IRQ_LINES),
      .EDGE_SUPPORT (1'b1)
   ) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_sync (pin_sync[IRQ_LINES-1:0]),
      .level    (level_q[IRQ_LINES-1:0]),
      .edge_any (edge_q[IRQ_LINES-1:0]),
      .irq      (irq_out)
   );

   assign pad_oe  = drive_q;
   assign pad_out = level_q;

endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
   import gpio_irq_pkg::*;
#(
   parameter int unsigned LINES     = 32,
   parameter int unsigned IRQ_LINES = 16,
   parameter int unsigned ADDR_W    = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [ADDR_W-1:0]    bus_addr,
   input logic                 bus_we,
   input logic [31:0]          bus_wdata,
   input logic [LINES-1:0]     pad_out,
   input logic [LINES-1:0]     pad_oe,
   input logic [IRQ_LINES-1:0] irq_out,
   input logic [LINES-1:0]     edge_mode,
   input logic [LINES-1:0]     pin_sync
);

   reg_sel_e         sel;
   logic [LINES-1:0] wm;
   logic             ignored_wr;

   assign sel        = decode_ofs(32'(bus_addr));
   assign wm         = bus_wdata[LINES-1:0];
   assign ignored_wr = bus_we && (sel == SEL_NONE || sel == SEL_PIN);

   AST_DRIVE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && sel == SEL_DRIVE) |=> (pad_oe == $past(wm))); // R2

   AST_RAISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && sel == SEL_RAISE) |=> ((pad_out & $past(wm)) == $past(wm))); // R4

   AST_DROP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && sel == SEL_DROP) |=> ((pad_out & $past(wm)) == '0)); // R5

   AST_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      ignored_wr |=> ($stable(pad_out) && $stable(pad_oe))); // R10

   for (genvar i = 0; i < IRQ_LINES; i++) begin : g_line_chk
      AST_LEVEL_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
         !edge_mode[i] |-> (irq_out[i] == (pin_sync[i] ^ pad_out[i]))); // R8

      AST_EDGE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
         (edge_mode[i] && irq_out[i]) |-> (pin_sync[i] != $past(pin_sync[i]))); // R9
   end

endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(
   .LINES     (LINES),
   .IRQ_LINES (IRQ_LINES),
   .ADDR_W    (ADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_we    (bus_we),
   .bus_wdata (bus_wdata),
   .pad_out   (pad_out),
   .pad_oe    (pad_oe),
   .irq_out   (irq_out),
   .edge_mode (edge_q),
   .pin_sync  (pin_sync)
);

// File: tb/gpio_irq_ctrl_bench.sv
module gpio_irq_ctrl_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = 8'h00;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] pad_in = '0;
   logic [31:0] pad_out, pad_oe;
   logic [15:0] irq_out;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   gpio_irq_ctrl u_gpio_irq_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pad_in    (pad_in),
      .pad_out   (pad_out),
      .pad_oe    (pad_oe),
      .irq_out   (irq_out)
   );

   // behavioural reference state
   logic [31:0] m_dir = '0, m_lvl = '0, m_mode = '0;
   logic [31:0] m_s1 = '0, m_s2 = '0, m_prev = '0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_dir = '0; m_lvl = '0; m_mode = '0;
         m_s1 = '0; m_s2 = '0; m_prev = '0;
      end else begin
         m_prev = m_s2;
         m_s2   = m_s1;
         m_s1   = pad_in;
         if (bus_we) begin
            case (bus_addr)
               8'h00: m_dir  = bus_wdata;
               8'h10: m_lvl  = bus_wdata;
               8'h18: m_lvl  = m_lvl | bus_wdata;
               8'h20: m_lvl  = m_lvl & ~bus_wdata;
               8'h30: m_mode = bus_wdata;
               default: ;
            endcase
         end
      end
   end

   function automatic logic [31:0] exp_read(input logic [7:0] a);
      case (a)
         8'h00:   return m_dir;
         8'h08:   return m_s2;
         8'h10:   return m_lvl;
         8'h30:   return m_mode;
         default: return 32'h0;
      endcase
   endfunction

   function automatic string read_tag(input logic [7:0] a);
      case (a)
         8'h00:   return "R2";
         8'h08:   return "R6";
         8'h10:   return "R3";
         8'h18:   return "R4";
         8'h20:   return "R5";
         8'h30:   return "R7";
         default: return "R10";
      endcase
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
      end
   endtask

   // per-cycle comparison against the reference, away from the active edge
   always @(negedge clk) begin
      if (!done) begin
         logic [15:0] e_irq;
         for (int i = 0; i < 16; i++)
            e_irq[i] = m_mode[i] ? (m_s2[i] ^ m_prev[i]) : (m_s2[i] ^ m_lvl[i]);
         if (!rst_n) begin
            check("R1 rdata", bus_rdata, 32'h0);
            check("R1 pad_oe", pad_oe, 32'h0);
            check("R1 pad_out", pad_out, 32'h0);
            check("R1 irq_out", {16'h0, irq_out}, 32'h0);
         end else begin
            check(read_tag(bus_addr), bus_rdata, exp_read(bus_addr));
            check("R2 pad_oe", pad_oe, m_dir);
            check("R3 pad_out", pad_out, m_lvl);
            check((m_mode[15:0] != 0) ? "R9 irq_out" : "R8 irq_out",
                  {16'h0, irq_out}, {16'h0, e_irq});
         end
      end
   end

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      bus_addr = a; bus_we = 1'b1; bus_wdata = d;
      @(posedge clk); #1;
      bus_we = 1'b0;
   endtask

   task automatic rd_check(input string tag, input logic [7:0] a, input logic [31:0] exp);
      @(posedge clk); #1;
      bus_addr = a;
      @(negedge clk);
      check(tag, bus_rdata, exp);
   endtask

   task automatic pins(input logic [31:0] v);
      @(posedge clk); #1;
      pad_in = v;
   endtask

   initial begin
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      rd_check("R1 edge reg after reset", 8'h30, 32'h0);

      wr(8'h00, 32'hF0F0_00FF);
      rd_check("R2 drive readback", 8'h00, 32'hF0F0_00FF);
      wr(8'h10, 32'h1234_5678);
      rd_check("R3 level readback", 8'h10, 32'h1234_5678);
      wr(8'h18, 32'h0000_FFFF);
      rd_check("R4 raise keeps other bits", 8'h10, 32'h1234_FFFF);
      rd_check("R4 raise offset reads zero", 8'h18, 32'h0);
      wr(8'h20, 32'hFF00_00F0);
      rd_check("R5 drop keeps other bits", 8'h10, 32'h0034_FF0F);
      rd_check("R5 drop offset reads zero", 8'h20, 32'h0);

      wr(8'h08, 32'hFFFF_FFFF);
      wr(8'h28, 32'hFFFF_FFFF);
      wr(8'h04, 32'hFFFF_FFFF);
      rd_check("R10 level untouched by stray writes", 8'h10, 32'h0034_FF0F);
      rd_check("R10 drive untouched by stray writes", 8'h00, 32'hF0F0_00FF);
      rd_check("R10 undefined offset reads zero", 8'h3C, 32'h0);

      pins(32'hA5A5_5A5A);
      rd_check("R6 pins not visible yet", 8'h08, 32'h0);
      @(negedge clk);
      check("R6 pins after two edges", bus_rdata, 32'hA5A5_5A5A);

      wr(8'h30, 32'h0000_00FF);
      rd_check("R7 edge readback", 8'h30, 32'h0000_00FF);
      for (int k = 0; k < 40; k++) pins(k[0] ? 32'hFFFF_FFFF : 32'h0);
      for (int k = 0; k < 20; k++) pins($urandom);

      for (int k = 0; k < 600; k++) begin
         logic [31:0] r;
         r = $urandom;
         @(posedge clk); #1;
         pad_in = (r[3:0] < 4'd6) ? $urandom : pad_in;
         bus_we = r[4];
         bus_wdata = $urandom;
         case (r[7:5])
            3'd0: bus_addr = 8'h00;
            3'd1: bus_addr = 8'h08;
            3'd2: bus_addr = 8'h10;
            3'd3: bus_addr = 8'h18;
            3'd4: bus_addr = 8'h20;
            3'd5: bus_addr = 8'h30;
            3'd6: bus_addr = 8'h28;
            default: bus_addr = 8'h3C;
         endcase
      end
      @(posedge clk); #1 bus_we = 1'b0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         bad++;
         total++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule